// File: doc/BRIEF.md
# Multi-Queue Status Flag Bus

This block puts the almost-full and almost-empty state of up to 32 FIFO queues onto two narrow 8-bit status buses. One bus carries almost-full status and the other carries almost-empty status. The buses report every configured queue, including queues that neither port has selected at the moment. The queue controller supplies one active-low flag per queue for each kind of status. This block only chooses which of those flags appear on the buses and registers them. It does not compute the flags.

When eight or fewer queues are configured, each bus lane belongs to one queue. When more queues are configured, the 32 queues form groups of eight, and one group is shown at a time. In polled mode the block steps through the populated groups one per clock. In direct mode the user names the group on an address input. In both modes the group being shown is driven on a group-address output, in the same cycle as the data it labels.

Top module: `qflag_status_bus`

## Requirements
- R1: While `rst_n` is low, both buses read 8'hFF and `grp_addr` reads 0.
- R2: When `q_count` is 8 or less, lane i of each bus shows queue i's flag one clock after it is sampled, and `grp_addr` is 0. In this case `direct_mode` and `grp_sel` have no effect.
- R3: In polled mode (`direct_mode`=0) with `q_count` above 8, `grp_addr` rises by one on each clock while it is below the last populated group. The last populated group is (`q_count`-1)/8.
- R4: In polled mode with `q_count` above 8, a `grp_addr` at or beyond the last populated group returns to 0 on the next clock.
- R5: In direct mode (`direct_mode`=1) with `q_count` above 8, the `grp_sel` value sampled on a clock edge appears on `grp_addr` after that edge. The buses then show group `grp_sel`.
- R6: A lane whose queue number (group*8 + lane) is at or above `q_count` reads 1, which means inactive. This includes every lane when `q_count` is 0.
- R7: Flags pass through without inversion, where 0 means asserted. Lane i of group g shows queue g*8+i from `af_n_vec` on `af_bus_n` and from `ae_n_vec` on `ae_bus_n`, and the two buses do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_count | input | 6 | Number of configured queues (0 to 32) |
| direct_mode | input | 1 | 1 selects addressed groups, 0 selects polling |
| grp_sel | input | 2 | Group requested in direct mode |
| af_n_vec | input | 32 | Per-queue almost-full flags, active low |
| ae_n_vec | input | 32 | Per-queue almost-empty flags, active low |
| af_bus_n | output | 8 | Registered almost-full lanes of the shown group |
| ae_bus_n | output | 8 | Registered almost-empty lanes of the shown group |
| grp_addr | output | 2 | Index of the group on the buses |

## Verification
The two flag vectors carry different patterns: different in each half-byte of each group and different between almost-full and almost-empty. A lane that is swapped, shifted or taken from the wrong group, or a bus fed from the other vector, therefore shows a wrong bit. Queue counts of 0, 5, 8, 9, 12, 20 and 32 separate the per-queue case from the grouped case and place the end of the padding in different lanes. Polled runs with three, four and two populated groups check where the walk wraps. A count change that leaves the current group out of range checks the early return to 0. The direct-mode entries include a group that is fully padded and a count of 8 with a nonzero group request, which must be ignored.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

  // Index of the highest group that holds at least one configured queue.
  function automatic int unsigned last_grp(int unsigned qc, int unsigned w);
    return (qc == 0) ? 0 : (qc - 1) / w;
  endfunction

  // A lane is live when its queue number lies below the configured count.
  function automatic logic lane_live(int unsigned grp, int unsigned lane,
                                     int unsigned w, int unsigned qc);
    return (grp * w + lane) < qc;
  endfunction

endpackage

// File: rtl/qfs_grp_seq.sv
module qfs_grp_seq #(
  parameter int BUS_W = 8,
  parameter int GA_W  = 2,
  parameter int CW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   q_count,
  input  logic            direct_mode,
  input  logic [GA_W-1:0] grp_sel,
  output logic [GA_W-1:0] grp_q,
  output logic [GA_W-1:0] grp_nxt,
  output logic            multi_grp,
  output logic            grp_wrap
);
  logic [GA_W-1:0] last;

  always_comb begin
    last      = GA_W'(qfs_pkg::last_grp(32'(q_count), BUS_W));
    multi_grp = q_count > CW'(BUS_W);
    grp_wrap  = multi_grp && !direct_mode && (grp_q >= last);
    if (!multi_grp)       grp_nxt = '0;
    else if (direct_mode) grp_nxt = grp_sel;
    else if (grp_wrap)    grp_nxt = '0;
    else                  grp_nxt = grp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_nxt;
  end
endmodule

// File: rtl/qfs_lane_mux.sv
module qfs_lane_mux #(
  parameter int NUM_Q = 32,
  parameter int BUS_W = 8,
  parameter int GA_W  = 2,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] flag_n,
  input  logic [GA_W-1:0]  grp,
  input  logic [CW-1:0]    q_count,
  output logic [BUS_W-1:0] bus_n
);
  localparam int IW = $clog2(NUM_Q);
  logic [BUS_W-1:0] lane_d;

  for (genvar l = 0; l < BUS_W; l++) begin : g_lane
    always_comb begin
      int idx;
      idx = 32'(grp) * BUS_W + l;
      lane_d[l] = 1'b1;
      if (qfs_pkg::lane_live(32'(grp), l, BUS_W, 32'(q_count)) && idx < NUM_Q)
        lane_d[l] = flag_n[idx[IW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_n <= '1;
    else        bus_n <= lane_d;
  end
endmodule

// File: rtl/qflag_status_bus.sv
module qflag_status_bus #(
  parameter int NUM_Q = 32,
  parameter int BUS_W = 8,
  localparam int GROUPS = NUM_Q / BUS_W,
  localparam int GA_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CW     = $clog2(NUM_Q + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    q_count,
  input  logic             direct_mode,
  input  logic [GA_W-1:0]  grp_sel,
  input  logic [NUM_Q-1:0] af_n_vec,
  input  logic [NUM_Q-1:0] ae_n_vec,
  output logic [BUS_W-1:0] af_bus_n,
  output logic [BUS_W-1:0] ae_bus_n,
  output logic [GA_W-1:0]  grp_addr
);
  logic [GA_W-1:0] grp_nxt;
  logic            multi_grp;
  logic            grp_wrap;

  qfs_grp_seq #(.BUS_W(BUS_W), .GA_W(GA_W), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .q_count(q_count), .direct_mode(direct_mode),
    .grp_sel(grp_sel), .grp_q(grp_addr), .grp_nxt(grp_nxt),
    .multi_grp(multi_grp), .grp_wrap(grp_wrap)
  );

  qfs_lane_mux #(.NUM_Q(NUM_Q), .BUS_W(BUS_W), .GA_W(GA_W), .CW(CW)) u_af (
    .clk(clk), .rst_n(rst_n), .flag_n(af_n_vec), .grp(grp_nxt),
    .q_count(q_count), .bus_n(af_bus_n)
  );

  qfs_lane_mux #(.NUM_Q(NUM_Q), .BUS_W(BUS_W), .GA_W(GA_W), .CW(CW)) u_ae (
    .clk(clk), .rst_n(rst_n), .flag_n(ae_n_vec), .grp(grp_nxt),
    .q_count(q_count), .bus_n(ae_bus_n)
  );
endmodule

// File: rtl/qfs_status_chk.sv
module qfs_status_chk #(
  parameter int NUM_Q = 32,
  parameter int BUS_W = 8,
  parameter int GA_W  = 2,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    q_count,
  input logic             direct_mode,
  input logic [GA_W-1:0]  grp_sel,
  input logic [BUS_W-1:0] af_bus_n,
  input logic [BUS_W-1:0] ae_bus_n,
  input logic [GA_W-1:0]  grp_addr,
  input logic             multi_grp
);
  logic [GA_W-1:0]  top_grp;
  logic [CW-1:0]    qc_d;
  logic [BUS_W-1:0] pad;

  // Number of populated groups minus one, by rounding up.
  assign top_grp = GA_W'((32'(q_count) + BUS_W - 1) / BUS_W - ((q_count == 0) ? 0 : 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qc_d <= '0;
    else        qc_d <= q_count;
  end

  always_comb begin
    for (int l = 0; l < BUS_W; l++)
      pad[l] = (32'(grp_addr) * BUS_W + l) >= 32'(qc_d);
  end

  p_single_grp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_grp |=> grp_addr == '0);

  p_poll_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_grp && !direct_mode && grp_addr < top_grp) |=> grp_addr == $past(grp_addr) + 1'b1);

  p_poll_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_grp && !direct_mode && grp_addr >= top_grp) |=> grp_addr == '0);

  p_direct_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_grp && direct_mode) |=> grp_addr == $past(grp_sel));

  p_pad_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((af_bus_n & pad) == pad) && ((ae_bus_n & pad) == pad));
endmodule

bind qflag_status_bus qfs_status_chk #(.NUM_Q(NUM_Q), .BUS_W(BUS_W), .GA_W(GA_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_count(q_count), .direct_mode(direct_mode),
  .grp_sel(grp_sel), .af_bus_n(af_bus_n), .ae_bus_n(ae_bus_n),
  .grp_addr(grp_addr), .multi_grp(multi_grp)
);

// File: tb/qflag_status_bus_test.sv
module qflag_status_bus_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  q_count = '0;
  logic        direct_mode = 1'b0;
  logic [1:0]  grp_sel = '0;
  logic [31:0] af_n_vec = '1;
  logic [31:0] ae_n_vec = '1;
  logic [7:0]  af_bus_n, ae_bus_n;
  logic [1:0]  grp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] mg = '0;

  always #5 clk = ~clk;

  qflag_status_bus uut (
    .clk(clk), .rst_n(rst_n), .q_count(q_count), .direct_mode(direct_mode),
    .grp_sel(grp_sel), .af_n_vec(af_n_vec), .ae_n_vec(ae_n_vec),
    .af_bus_n(af_bus_n), .ae_bus_n(ae_bus_n), .grp_addr(grp_addr)
  );

  typedef struct packed {
    logic [5:0]  q;
    logic        dir;
    logic [1:0]  sel;
    logic [31:0] af;
    logic [31:0] ae;
    logic [1:0]  grp;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{6'd8,  1'b0, 2'd0, 32'h1234_56A5, 32'hFFFF_FF5A, 2'd0},  // R2 R7
    '{6'd8,  1'b1, 2'd3, 32'h0000_00C3, 32'h0000_003C, 2'd0},  // R2 selection ignored
    '{6'd5,  1'b0, 2'd0, 32'h0000_0000, 32'h0000_0012, 2'd0},  // R6
    '{6'd32, 1'b1, 2'd2, 32'h00E1_0000, 32'h0096_0000, 2'd2},  // R5
    '{6'd32, 1'b1, 2'd3, 32'h7B00_0000, 32'h8400_0000, 2'd3},  // R5
    '{6'd20, 1'b1, 2'd2, 32'h0000_0000, 32'h0009_0000, 2'd2},  // R6
    '{6'd20, 1'b1, 2'd3, 32'h0000_0000, 32'h0000_0000, 2'd3},  // R6 all padded
    '{6'd0,  1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 2'd0},  // R6 no queues
    '{6'd9,  1'b1, 2'd1, 32'h0000_0000, 32'hFFFF_FE00, 2'd1}   // R6 single live lane
  };

  // Lane model: queue g*8+b if configured, otherwise inactive high.
  function automatic logic [7:0] lanes(logic [31:0] v, logic [1:0] g, logic [5:0] q);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      int n;
      n = int'(g) * 8 + b;
      r[b] = (n < int'(q)) ? v[n] : 1'b1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [5:0] q, logic dir, logic [1:0] sel,
                      logic [31:0] af, logic [31:0] ae, string tag);
    int groups;
    q_count = q; direct_mode = dir; grp_sel = sel; af_n_vec = af; ae_n_vec = ae;
    @(posedge clk);
    groups = (int'(q) + 7) / 8;
    if (q <= 8)      mg = 2'd0;
    else if (dir)    mg = sel;
    else if (int'(mg) + 1 >= groups) mg = 2'd0;
    else             mg = mg + 2'd1;
    @(negedge clk);
    chk({tag, " grp"}, {6'd0, grp_addr}, {6'd0, mg});
    chk({tag, " af"}, af_bus_n, lanes(af, mg, q));
    chk({tag, " ae"}, ae_bus_n, lanes(ae, mg, q));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds idle outputs despite live inputs
    q_count = 6'd32; direct_mode = 1'b1; grp_sel = 2'd3; af_n_vec = '0; ae_n_vec = '0;
    repeat (3) @(negedge clk);
    chk("R1 af", af_bus_n, 8'hFF);
    chk("R1 ae", ae_bus_n, 8'hFF);
    chk("R1 grp", {6'd0, grp_addr}, 8'h00);
    rst_n = 1'b1;
    mg = '0;

    for (int i = 0; i < 9; i++) begin
      step(TBL[i].q, TBL[i].dir, TBL[i].sel, TBL[i].af, TBL[i].ae, "R7 table");
      chk("R5 table grp", {6'd0, grp_addr}, {6'd0, TBL[i].grp});
    end

    // R3 R4: polled walk over three groups
    for (int i = 0; i < 7; i++)
      step(6'd20, 1'b0, 2'd3, 32'hA5C3_0F81, 32'h5A3C_F07E, "R3 poll20");
    // R3 R4: four groups
    for (int i = 0; i < 6; i++)
      step(6'd32, 1'b0, 2'd0, 32'h1E2D_3C4B, 32'hE1D2_C3B4, "R4 poll32");
    while (grp_addr != 2'd3)
      step(6'd32, 1'b0, 2'd0, 32'h1E2D_3C4B, 32'hE1D2_C3B4, "R3 poll32");
    // R4: count shrinks while shown group is out of range
    step(6'd12, 1'b0, 2'd0, 32'h0000_0A50, 32'h0000_05AF, "R4 shrink");
    for (int i = 0; i < 4; i++)
      step(6'd9, 1'b0, 2'd2, 32'h0000_0100, 32'h0000_0066, "R4 poll9");
    // R2: polled mode with few queues stays on group 0
    for (int i = 0; i < 2; i++)
      step(6'd7, 1'b0, 2'd1, 32'h0000_0033, 32'h0000_0044, "R2 poll7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule